// File: doc/BRIEF.md
# Dual-Channel Simultaneous Sampling Sequencer

This block sequences a two-channel converter that samples both of its inputs at the same instant. Any of four start sources launches a conversion while the block is idle: two event sources, a software strobe and an external start input. The block then drives a sample/hold pulse whose width is set by a 4-bit acquisition setting. Both channels are sampled together on the falling edge of that pulse. One 3-bit index drives the pair selection, so bank A and bank B always use the same channel number.

After each sampling instant, the block captures the bank-A converter word into one result register and then the bank-B word into a second result register, each at a fixed latency. Two clocks after the bank-B capture it raises a sticky interrupt flag. When the continuous enable is held high, the block starts the next sample/hold pulse on its own. Successive results are then spaced by the acquisition setting. The converter clock and the system clock are the same clock `clk`.

Top module: `ss_sampler`

## Requirements
- R1: When reset is asserted, `sh_pulse`, `pair_sel`, `res_a`, `res_b` and `irq_flag` are all zero.
- R2: While idle, a high level on any of `trig_eva`, `trig_evb`, `trig_sw` or `trig_ext` at a rising edge (the accept edge) starts a sequence. From the accept edge on, `pair_sel` shows the `pair_in` index, which applies to both banks.
- R3: `sh_pulse` rises on the falling clock edge 2.5 clock periods after the accept edge. It stays high for exactly 1 + ACQ clock periods, where ACQ is the 4-bit `acq_in` value (0 to 15).
- R4: Call the rising edge half a period before the sample/hold falling edge the sample edge. `res_a` takes `conv_a` at the rising edge 4 clocks after the sample edge. `res_b` takes `conv_b` at the rising edge 5 clocks after it. Each register captures the input value present just before that edge.
- R5: While `cont_en` is high at a sample edge, the next sample/hold pulse rises 2.5 clocks after that edge. Successive A and B updates are therefore spaced by 3 + ACQ clocks. If `cont_en` is low at a sample edge, the block returns to idle.
- R6: `irq_flag` rises 2 clocks after a bank-B update. It stays set until `irq_clr` is high at a rising edge. If a set and a clear fall in the same cycle, the set wins.
- R7: Start inputs that arrive while a sequence is active are ignored. They change neither the pulse timing nor `pair_sel`.
- R8: `acq_in` and `pair_in` are captured only at the accept edge. Changes to them during a sequence do not alter its pulse width, result timing or `pair_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter/system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_eva | input | 1 | Start from event source A |
| trig_evb | input | 1 | Start from event source B |
| trig_sw | input | 1 | Software start strobe |
| trig_ext | input | 1 | External start-of-conversion input |
| cont_en | input | 1 | Continuous sampling enable |
| acq_in | input | 4 | Acquisition setting ACQ (pulse = 1 + ACQ clocks) |
| pair_in | input | 3 | Channel pair index |
| conv_a | input | 12 | Bank-A converter data |
| conv_b | input | 12 | Bank-B converter data |
| irq_clr | input | 1 | Clears the interrupt flag when high (write-one-to-clear) |
| sh_pulse | output | 1 | Sample/hold pulse |
| pair_sel | output | 3 | Pair index applied to both banks |
| res_a | output | 12 | Bank-A result register |
| res_b | output | 12 | Bank-B result register |
| irq_flag | output | 1 | Sticky conversion-done flag |

## Verification
A wrong hold counter or a wrongly latched acquisition value shows up at once as a sample/hold falling edge at the wrong half-cycle. The same fault then moves every later result edge by the same amount. A fault in the result pipeline shows within four or five clocks of the sampling edge, as a result register that changes at the wrong time or holds a word captured one cycle off. A busy flag that leaks lets a stray start add sample/hold edges and result updates that the scoreboard never expected. These extra events are reported when they appear.

// File: rtl/ss_sampler.sv
module ss_sampler #(
  parameter int DW = 12,
  parameter int AW = 4,
  parameter int PW = 3,
  parameter int ALAT = 4,
  parameter int IRQ_GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_eva,
  input  logic          trig_evb,
  input  logic          trig_sw,
  input  logic          trig_ext,
  input  logic          cont_en,
  input  logic [AW-1:0] acq_in,
  input  logic [PW-1:0] pair_in,
  input  logic [DW-1:0] conv_a,
  input  logic [DW-1:0] conv_b,
  input  logic          irq_clr,
  output logic          sh_pulse,
  output logic [PW-1:0] pair_sel,
  output logic [DW-1:0] res_a,
  output logic [DW-1:0] res_b,
  output logic          irq_flag
);
  localparam int PL = ALAT + 1 + IRQ_GAP;

  typedef enum logic [1:0] {IDLE, GAP, HOLD} ph_t;

  ph_t           ph;
  logic [AW-1:0] cnt, acq_l;
  logic          sh_r;
  logic [PL-1:0] pipe;

  wire start = (ph == IDLE) && (trig_eva | trig_evb | trig_sw | trig_ext);
  wire last  = (ph == HOLD) && (cnt == acq_l);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= IDLE; cnt <= '0; acq_l <= '0; pair_sel <= '0; sh_r <= 1'b0;
    end else begin
      case (ph)
        IDLE: if (start) begin
          ph <= GAP; cnt <= '0; acq_l <= acq_in; pair_sel <= pair_in;
        end
        GAP: if (cnt == AW'(1)) begin
          ph <= HOLD; cnt <= '0; sh_r <= 1'b1;
        end else cnt <= cnt + 1'b1;
        HOLD: if (last) begin
          sh_r <= 1'b0; cnt <= '0; ph <= cont_en ? GAP : IDLE;
        end else cnt <= cnt + 1'b1;
        default: ph <= IDLE;
      endcase
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) sh_pulse <= 1'b0;
    else        sh_pulse <= sh_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pipe <= '0; res_a <= '0; res_b <= '0; irq_flag <= 1'b0;
    end else begin
      pipe <= {pipe[PL-2:0], last};
      if (pipe[ALAT-1]) res_a <= conv_a;
      if (pipe[ALAT])   res_b <= conv_b;
      if (pipe[PL-1])   irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end

  logic [AW:0] wcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    wcnt <= '0;
    else if (sh_r) wcnt <= wcnt + 1'b1;
    else           wcnt <= '0;

  a_r3_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_r) |-> (wcnt == (AW+1)'(acq_l) + 1'b1));

  a_r8_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != IDLE) |=> ($stable(pair_sel) && $stable(acq_l)));

  a_r5_gap_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_r) |-> !$past(sh_r, 2));

  a_r6_irq_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(last, 8));
endmodule

// File: tb/ss_sampler_test.sv
`timescale 1ns/1ps
module ss_sampler_test;
  logic clk = 0, rst_n = 0;
  logic trig_eva = 0, trig_evb = 0, trig_sw = 0, trig_ext = 0, cont_en = 0, irq_clr = 0;
  logic [3:0] acq_in = 0;
  logic [2:0] pair_in = 0;
  logic [11:0] conv_a = 0, conv_b = 0;
  logic sh_pulse, irq_flag;
  logic [2:0] pair_sel;
  logic [11:0] res_a, res_b;

  ss_sampler uut (.clk(clk), .rst_n(rst_n), .trig_eva(trig_eva), .trig_evb(trig_evb),
    .trig_sw(trig_sw), .trig_ext(trig_ext), .cont_en(cont_en), .acq_in(acq_in),
    .pair_in(pair_in), .conv_a(conv_a), .conv_b(conv_b), .irq_clr(irq_clr),
    .sh_pulse(sh_pulse), .pair_sel(pair_sel), .res_a(res_a), .res_b(res_b),
    .irq_flag(irq_flag));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int q_rise[$], q_fall[$], q_at[$], q_av[$], q_bt[$], q_bv[$], q_irq[$];

  function automatic int fa(int t); return (t * 7 + 1) & 'hfff; endfunction
  function automatic int fb(int t); return (t * 5 + 3) & 'hfff; endfunction

  always @(negedge clk) begin
    conv_a <= 12'(fa(int'($time)));
    conv_b <= 12'(fb(int'($time)));
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic popq(ref int q[$], input int act, input string r);
    if (q.size() == 0) chk(0, {r, " unexpected"}, act, -1);
    else begin
      int e = q.pop_front();
      chk(act == e, r, act, e);
    end
  endtask

  logic p_sh = 0, p_irq = 0;
  logic [11:0] p_a = 0, p_b = 0;
  always begin
    @(posedge clk or negedge clk);
    #1;
    if (rst_n) begin
      if (sh_pulse && !p_sh) popq(q_rise, int'($time) - 1, "R3 sh rise time");
      if (!sh_pulse && p_sh) popq(q_fall, int'($time) - 1, "R3 sh fall time");
      if (res_a != p_a) begin
        popq(q_at, int'($time) - 1, "R4 res_a time");
        popq(q_av, int'(res_a), "R4 res_a value");
      end
      if (res_b != p_b) begin
        popq(q_bt, int'($time) - 1, "R4 res_b time");
        popq(q_bv, int'(res_b), "R4 res_b value");
      end
      if (irq_flag && !p_irq) popq(q_irq, int'($time) - 1, "R6 irq rise time");
    end
    p_sh = sh_pulse; p_irq = irq_flag; p_a = res_a; p_b = res_b;
  end

  // src: 0 event A, 1 event B, 2 software, 3 external
  task automatic run(input int src, input int acq, input int pair, input int n, input bit busy);
    int t0, per;
    per = 4 * (3 + acq);
    @(negedge clk);
    acq_in = 4'(acq); pair_in = 3'(pair); cont_en = (n > 1);
    case (src)
      0: trig_eva = 1;
      1: trig_evb = 1;
      2: trig_sw = 1;
      default: trig_ext = 1;
    endcase
    t0 = int'($time) + 2;
    for (int i = 0; i < n; i++) begin
      int es = t0 + (i + 1) * per;
      q_rise.push_back(es - per + 10);
      q_fall.push_back(es + 2);
      q_at.push_back(es + 16); q_av.push_back(fa(es + 14));
      q_bt.push_back(es + 20); q_bv.push_back(fb(es + 18));
    end
    q_irq.push_back(t0 + per + 28);
    @(negedge clk);
    trig_eva = 0; trig_evb = 0; trig_sw = 0; trig_ext = 0;
    chk(pair_sel == 3'(pair), "R2 pair_sel after accept", int'(pair_sel), pair);
    if (busy) begin
      @(negedge clk); @(negedge clk);
      trig_ext = 1; trig_sw = 1; acq_in = ~acq_in; pair_in = ~pair_in;
      @(negedge clk);
      trig_ext = 0; trig_sw = 0;
      chk(pair_sel == 3'(pair), "R7 R8 pair_sel after busy start", int'(pair_sel), pair);
    end
    if (n > 1) begin
      while (int'($time) < t0 + (n - 1) * per + 2) @(negedge clk);
      cont_en = 0;
    end
    while (int'($time) < t0 + n * per + 40) @(negedge clk);
    chk(q_rise.size() + q_fall.size() + q_at.size() + q_bt.size() + q_irq.size() == 0,
        "R5 all expected events seen", q_at.size(), 0);
    chk(pair_sel == 3'(pair), "R8 pair_sel held", int'(pair_sel), pair);
    chk(irq_flag == 1, "R6 irq sticky", int'(irq_flag), 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    chk(irq_flag == 0, "R6 irq cleared", int'(irq_flag), 0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    #5;
    // R1 reset state
    chk(sh_pulse == 0 && irq_flag == 0, "R1 reset sh/irq", int'({sh_pulse, irq_flag}), 0);
    chk(pair_sel == 0, "R1 reset pair_sel", int'(pair_sel), 0);
    chk(res_a == 0 && res_b == 0, "R1 reset results", int'(res_a) + int'(res_b), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    run(0, 0, 3, 1, 0);   // R2 R3 R4 minimum pulse, event source A
    run(1, 15, 5, 1, 0);  // R3 maximum pulse, event source B
    run(2, 7, 0, 1, 1);   // R7 R8 busy start and setting changes
    run(3, 2, 7, 4, 0);   // R5 continuous, external start
    run(0, 0, 1, 3, 0);   // R5 continuous, tightest spacing
    run(3, 9, 6, 1, 1);   // R7 R8 again with wide pulse
    finish_run();
  end
endmodule